// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block decides whether a device runs from its main supply or from its backup cell. It sees digitised voltages as unsigned millivolt codes: the main rail (VDD), the backup cell (VBAT) and the cell's nominal voltage. Once per sample strobe it applies a hysteretic rule to pick the active supply. Moving onto the backup cell needs two conditions at once. Moving back to the main rail needs only one of two.

The block also gates the serial host interface. While the backup cell is in use the interface is switched off, unless a host-set enable bit allows it to stay on. Two sticky warning flags report a weakening backup cell, at 85% and at 75% of its nominal value. These flags stay set until the host pulses a clear.

Top module: `supply_switchover`

## Requirements
- R1: After reset the block is in main-supply mode (`on_backup`=0), `bus_enable`=1, and both warning flags are 0.
- R2: On a strobe cycle in main-supply mode, the block moves to backup mode only when `vdd_mv + 50 < vbat_mv` and also `vdd_mv < 2200`, both strictly.
- R3: On a strobe cycle in backup mode, the block returns to main-supply mode when `vdd_mv > vbat_mv + 50` or when `vdd_mv > 2230`.
- R4: `on_backup` changes only after a cycle with `sample_stb`=1, and it takes its new value in the cycle that follows. In cycles without a strobe it holds, whatever the voltage codes are.
- R5: `bus_enable` is 0 exactly when `on_backup`=1 and `bus_in_backup_en`=0. It is 1 in every other case. It follows both inputs in the same cycle.
- R6: A strobe with `vbat_mv < floor(vbat_nom_mv*85/100)` sets `warn_low` from the next cycle on.
- R7: A strobe with `vbat_mv < floor(vbat_nom_mv*75/100)` sets `warn_crit` from the next cycle on.
- R8: Both warning flags are sticky. They clear only when `warn_clr` is 1, and they do not clear if their set condition holds in that same cycle (set wins over clear).
- R9: Equality never triggers a change. With `vdd_mv + 50 == vbat_mv` or `vdd_mv == 2200` the block stays in main-supply mode. With `vdd_mv == vbat_mv + 50` and `vdd_mv == 2230` it stays in backup mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | Voltage codes are valid; evaluate the rules |
| vdd_mv | input | 13 | Main rail voltage in mV |
| vbat_mv | input | 13 | Backup cell voltage in mV |
| vbat_nom_mv | input | 13 | Nominal backup cell voltage in mV |
| bus_in_backup_en | input | 1 | Keep the serial interface on in backup mode |
| warn_clr | input | 1 | Clear strobe for the warning flags |
| on_backup | output | 1 | 1 while running from the backup cell |
| bus_enable | output | 1 | Serial interface gate |
| warn_low | output | 1 | Sticky flag: cell below 85% of nominal |
| warn_crit | output | 1 | Sticky flag: cell below 75% of nominal |

## Verification
A wrong mode register shows up on `on_backup` and `bus_enable` one cycle after the strobe that should have moved it. It stays wrong until a later strobe satisfies the opposite rule. Sweeps that raise and lower VDD against several VBAT values would therefore show a shifted or missing hysteresis band at once. A threshold rounded the wrong way, or a flag that is not sticky, shows up on the warning outputs on the cycle after the first strobe that sits at the border. Sweeping VBAT one millivolt at a time places that strobe exactly on the floored threshold.

// File: rtl/supply_sw_pkg.sv
package supply_sw_pkg;

  typedef enum logic {MODE_MAIN = 1'b0, MODE_BACKUP = 1'b1} pwr_mode_e;

  // Entry into backup: both strict conditions, no subtraction (no underflow)
  function automatic logic enter_ok(logic [31:0] vdd, logic [31:0] vbat,
                                    logic [31:0] hys, logic [31:0] trip);
    return ((vdd + hys) < vbat) && (vdd < trip);
  endfunction

  // Return to main: either strict condition
  function automatic logic leave_ok(logic [31:0] vdd, logic [31:0] vbat,
                                    logic [31:0] hys_b, logic [31:0] trip,
                                    logic [31:0] hys_t);
    return (vdd > (vbat + hys_b)) || (vdd > (trip + hys_t));
  endfunction

  // floor(v * pct / 100)
  function automatic logic [31:0] pct_floor(logic [31:0] v, logic [31:0] pct);
    return (v * pct) / 32'd100;
  endfunction

  function automatic logic below_pct(logic [31:0] vbat, logic [31:0] nom,
                                     logic [31:0] pct);
    return vbat < pct_floor(nom, pct);
  endfunction

endpackage

// File: rtl/supply_mode_fsm.sv
module supply_mode_fsm
  import supply_sw_pkg::*;
#(
  parameter int unsigned W        = 13,
  parameter int unsigned HYS_BAT  = 50,
  parameter int unsigned TRIP     = 2200,
  parameter int unsigned HYS_TRIP = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] vdd,
  input  logic [W-1:0] vbat,
  output logic         on_backup,
  output logic         enter_hit,
  output logic         leave_hit
);

  localparam logic [31:0] HB = 32'(HYS_BAT);
  localparam logic [31:0] TR = 32'(TRIP);
  localparam logic [31:0] HT = 32'(HYS_TRIP);

  pwr_mode_e mode_q, mode_d;

  always_comb begin
    enter_hit = enter_ok(32'(vdd), 32'(vbat), HB, TR);
    leave_hit = leave_ok(32'(vdd), 32'(vbat), HB, TR, HT);
  end

  always_comb begin
    mode_d = mode_q;
    if (stb) begin
      if (mode_q == MODE_MAIN && enter_hit)        mode_d = MODE_BACKUP;
      else if (mode_q == MODE_BACKUP && leave_hit) mode_d = MODE_MAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_MAIN;
    else        mode_q <= mode_d;
  end

  assign on_backup = (mode_q == MODE_BACKUP);

  // R2: both entry conditions on a strobe take the block to backup
  assert_enter_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !on_backup && enter_hit) |=> on_backup);
  // R9: a strobe without both strict conditions keeps main mode
  assert_enter_strict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !on_backup && ((32'(vdd) + HB >= 32'(vbat)) || (32'(vdd) >= TR)))
    |=> !on_backup);
  // R3: either exit condition on a strobe returns to main
  assert_leave_either_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && on_backup && leave_hit) |=> !on_backup);
  // R4: no strobe, no mode change
  assert_hold_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(on_backup));

endmodule

// File: rtl/batt_level_flag.sv
module batt_level_flag
  import supply_sw_pkg::*;
#(
  parameter int unsigned W   = 13,
  parameter int unsigned PCT = 85
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         clr,
  input  logic [W-1:0] vbat,
  input  logic [W-1:0] nom,
  output logic         flag,
  output logic         set_hit
);

  localparam logic [31:0] P = 32'(PCT);

  always_comb set_hit = stb && below_pct(32'(vbat), 32'(nom), P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_hit) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  // R6/R7: a qualifying strobe sets the flag
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> flag);
  // R8: a set flag stays set without a clear
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R8: the flag rises only after a qualifying strobe
  assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_hit));

endmodule

// File: rtl/supply_switchover.sv
module supply_switchover
  import supply_sw_pkg::*;
#(
  parameter int unsigned W        = 13,
  parameter int unsigned HYS_BAT  = 50,
  parameter int unsigned TRIP     = 2200,
  parameter int unsigned HYS_TRIP = 30,
  parameter int unsigned LOW_PCT  = 85,
  parameter int unsigned CRIT_PCT = 75
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_stb,
  input  logic [W-1:0] vdd_mv,
  input  logic [W-1:0] vbat_mv,
  input  logic [W-1:0] vbat_nom_mv,
  input  logic         bus_in_backup_en,
  input  logic         warn_clr,
  output logic         on_backup,
  output logic         bus_enable,
  output logic         warn_low,
  output logic         warn_crit
);

  localparam int unsigned NLVL = 2;

  logic            enter_hit, leave_hit;
  logic [NLVL-1:0] lvl_flag, lvl_set;

  supply_mode_fsm #(
    .W(W), .HYS_BAT(HYS_BAT), .TRIP(TRIP), .HYS_TRIP(HYS_TRIP)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .stb(sample_stb),
    .vdd(vdd_mv), .vbat(vbat_mv),
    .on_backup(on_backup), .enter_hit(enter_hit), .leave_hit(leave_hit)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam int unsigned P = (g == 0) ? LOW_PCT : CRIT_PCT;
    batt_level_flag #(.W(W), .PCT(P)) u_flag (
      .clk(clk), .rst_n(rst_n), .stb(sample_stb), .clr(warn_clr),
      .vbat(vbat_mv), .nom(vbat_nom_mv),
      .flag(lvl_flag[g]), .set_hit(lvl_set[g])
    );
  end

  assign warn_low   = lvl_flag[0];
  assign warn_crit  = lvl_flag[1];
  assign bus_enable = !on_backup || bus_in_backup_en;

  // R5: interface is never on in backup mode without the enable bit
  assert_bus_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (on_backup && !bus_in_backup_en) |-> !bus_enable);
  // R5: interface always on in main mode
  assert_bus_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !on_backup |-> bus_enable);
  // R7: the deeper warning never stands without the shallower one
  assert_crit_implies_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    warn_crit |-> warn_low);

endmodule

// File: tb/sim_supply_switchover.sv
module sim_supply_switchover;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_stb = 1'b0;
  logic [12:0] vdd_mv = '0, vbat_mv = '0, vbat_nom_mv = '0;
  logic        bus_in_backup_en = 1'b0, warn_clr = 1'b0;
  logic        on_backup, bus_enable, warn_low, warn_crit;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  // reference state
  bit m_bk = 0, m_wl = 0, m_wc = 0;

  always #5 clk = ~clk;

  supply_switchover u0 (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .vdd_mv(vdd_mv), .vbat_mv(vbat_mv), .vbat_nom_mv(vbat_nom_mv),
    .bus_in_backup_en(bus_in_backup_en), .warn_clr(warn_clr),
    .on_backup(on_backup), .bus_enable(bus_enable),
    .warn_low(warn_low), .warn_crit(warn_crit)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  // one cycle: drive, advance reference, compare all outputs
  task automatic step(input int vd, input int vb, input int nm, input bit s,
                      input bit c, input bit e, input string mtag);
    bit ent, lv, b1, b2;
    @(negedge clk);
    vdd_mv = 13'(vd); vbat_mv = 13'(vb); vbat_nom_mv = 13'(nm);
    sample_stb = s; warn_clr = c; bus_in_backup_en = e;
    ent = (vd < vb - 50) && (vd < 2200);
    lv  = (vd - 50 > vb) || (vd >= 2231);
    b1  = (vb + 1) * 100 <= nm * 85;
    b2  = (vb + 1) * 100 <= nm * 75;
    if (s) begin
      if (!m_bk && ent) m_bk = 1;
      else if (m_bk && lv) m_bk = 0;
    end
    if (s && b1) m_wl = 1; else if (c) m_wl = 0;
    if (s && b2) m_wc = 1; else if (c) m_wc = 0;
    @(posedge clk); #1;
    chk(mtag, on_backup, m_bk);
    chk("R5", bus_enable, !m_bk || e);
    chk("R6", warn_low, m_wl);
    chk("R7", warn_crit, m_wc);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int vbl[7] = '{1800, 2100, 2200, 2250, 2300, 3000, 3300};
    repeat (3) @(posedge clk);
    #1;
    chk("R1", on_backup, 1'b0);
    chk("R1", bus_enable, 1'b1);
    chk("R1", warn_low, 1'b0);
    chk("R1", warn_crit, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3 hysteresis sweeps, down then up, per VBAT value
    foreach (vbl[k]) begin
      for (int v = 2700; v >= 1700; v -= 5)
        step(v, vbl[k], 3000, 1'b1, 1'b1, v[0], "R2");
      for (int v = 1700; v <= 2700; v += 5)
        step(v, vbl[k], 3000, 1'b1, 1'b1, v[1], "R3");
    end

    // R4: conditions present but no strobe
    step(2000, 3000, 3000, 1'b1, 1'b1, 1'b0, "R3");
    step(2500, 3000, 3000, 1'b1, 1'b1, 1'b0, "R3");
    step(1900, 3000, 3000, 1'b0, 1'b1, 1'b0, "R4");
    chk("R4", on_backup, 1'b0);
    step(1900, 3000, 3000, 1'b0, 1'b1, 1'b1, "R4");
    step(1900, 3000, 3000, 1'b1, 1'b1, 1'b0, "R4");
    chk("R4", on_backup, 1'b1);
    step(2600, 3000, 3000, 1'b0, 1'b1, 1'b0, "R4");
    chk("R4", on_backup, 1'b1);

    // R9 borders
    step(2600, 3000, 3000, 1'b1, 1'b1, 1'b0, "R9");
    step(2150, 2200, 3000, 1'b1, 1'b1, 1'b0, "R9");
    chk("R9", on_backup, 1'b0);
    step(2200, 3000, 3000, 1'b1, 1'b1, 1'b0, "R9");
    chk("R9", on_backup, 1'b0);
    step(2149, 2200, 3000, 1'b1, 1'b1, 1'b0, "R9");
    chk("R9", on_backup, 1'b1);
    step(2230, 2180, 3000, 1'b1, 1'b1, 1'b0, "R9");
    chk("R9", on_backup, 1'b1);
    step(2231, 2181, 3000, 1'b1, 1'b1, 1'b0, "R9");
    chk("R9", on_backup, 0);

    // R6/R7 threshold sweeps at 1 mV, clearing each cycle
    for (int nmi = 3000; nmi <= 3003; nmi++)
      for (int b = 2600; b >= 2200; b--)
        step(2600, b, nmi, 1'b1, 1'b1, 1'b0, "R6");

    // R8 stickiness and set-over-clear
    step(2600, 2000, 3000, 1'b1, 1'b0, 1'b0, "R8");
    step(2600, 3000, 3000, 1'b1, 1'b0, 1'b0, "R8");
    chk("R8", warn_low, 1'b1);
    chk("R8", warn_crit, 1'b1);
    step(2600, 2400, 3000, 1'b1, 1'b1, 1'b0, "R8");
    chk("R8", warn_low, 1'b1);
    chk("R8", warn_crit, 1'b0);
    step(2600, 3000, 3000, 1'b0, 1'b1, 1'b0, "R8");
    chk("R8", warn_low, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule